// File: doc/BRIEF.md
# Serial Link Power-Up Sequencer

This block is the transmitting-side controller that brings a two-wire serial display link, made of one clock line and one data line, out of its zero-current state and into continuous operation. It watches an active-low power-down input. While that input is low, both line drivers stay disabled. Once the input goes high, the block waits a fixed number of reference cycles, which stands in for the PLL lock time. It then plays a three-part calibration preamble on the lines, so the far end can trim its receivers, and finally runs the clock line continuously at a divided reference rate.

For each line the block produces a drive enable and a logic level. It also reports a 2-bit link-phase code. Once the clock is running, payload bits can be handed in over a one-bit valid/ready interface. `tx_ready` is high only while the clock runs. A bit offered while `tx_ready` is low is not taken and leaves the lines unchanged, so the source must hold it until ready. A bit is placed on the data line in the same cycle that `tx_valid` and `tx_ready` are both high. Framing of the payload is left to the source.

Top module: `link_bringup`

## Requirements
- R1: While `rst_n` is low, and from the first clock edge at which `pwr_dn_n` is sampled low, both drive enables and both levels are 0, `tx_ready` is 0, and `phase` reads OFF (code 0).
- R2: From the first edge at which `pwr_dn_n` is sampled high in OFF, the block spends exactly LOCK_CYC (default 4096) cycles with both drivers off and `phase` at LINK-UP (code 1).
- R3: The first preamble segment lasts SEG_CYC (default 11) cycles. In it the clock line is driven (enable 1) at level 0 and the data driver is off.
- R4: The second segment lasts SEG_CYC cycles. In it the clock line is driven at level 1 and the data driver is off.
- R5: The third segment lasts SEG_CYC cycles. In it both lines are driven at level 0. `phase` stays LINK-UP through all three segments.
- R6: After the preamble, the clock line stays driven and toggles without stop. Its first level is 1, and each half period lasts 2^`rate_sel` reference cycles (rate_sel 0..3 gives a divide ratio of 2, 4, 8 or 16).
- R7: While the clock runs and `tx_valid` is low, `phase` reads IDLE (code 2) and the data line is driven at level 0.
- R8: While the clock runs, `tx_ready` is 1. When `tx_valid` is high, `phase` reads ACTIVE (code 3) and the data level equals `tx_bit` in the same cycle. Before the clock runs, `tx_valid` has no effect on any output.
- R9: LINK-UP is entered only from OFF. A power-down at any point discards all progress, so the next release again waits the full LOCK_CYC cycles and replays the whole preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Power-down, active low; high releases the link |
| rate_sel | input | 2 | Half-period select for the running clock line, 2^rate_sel cycles |
| tx_valid | input | 1 | Payload bit offered |
| tx_bit | input | 1 | Payload bit value |
| tx_ready | output | 1 | Payload bit accepted this cycle when valid |
| clk_oe | output | 1 | Clock-line driver enable |
| clk_lvl | output | 1 | Clock-line logic level |
| dat_oe | output | 1 | Data-line driver enable |
| dat_lvl | output | 1 | Data-line logic level |
| phase | output | 2 | Link phase: 0 OFF, 1 LINK-UP, 2 IDLE, 3 ACTIVE |

## Verification
On every cycle, the assertions check the following: power-down leads to OFF at the next edge, LINK-UP is entered only from OFF, the segment and half-period counters stay within their limits, the clock line toggles only when its half period ends, and `tx_ready` never rises unless both drivers are on. Some behaviour can only be shown by the bench's scenarios, because it is checked against a cycle-indexed model of the whole sequence. This covers the exact 4096-cycle lock wait, the exact length and levels of each preamble segment, the waveform produced by each rate setting, and the full restart after a power-down taken in the lock wait, in the preamble, or while the clock runs.

// File: rtl/link_bringup_pkg.sv
package link_bringup_pkg;

  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_LINKUP = 2'd1,
    PH_IDLE   = 2'd2,
    PH_ACTIVE = 2'd3
  } phase_t;

  typedef enum logic [2:0] {
    S_OFF      = 3'd0,
    S_LOCK     = 3'd1,
    S_CAL_LO   = 3'd2,
    S_CAL_HI   = 3'd3,
    S_CAL_BOTH = 3'd4,
    S_RUN      = 3'd5
  } seq_state_t;

endpackage

// File: rtl/lbu_step_fsm.sv
module lbu_step_fsm
  import link_bringup_pkg::*;
#(
  parameter int LOCK_CYC = 4096,
  parameter int SEG_CYC  = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_dn_n,
  output seq_state_t state
);
  localparam int MAXC = (LOCK_CYC > SEG_CYC) ? LOCK_CYC : SEG_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);
  localparam logic [CW-1:0] SEG_LAST  = CW'(SEG_CYC - 1);

  seq_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    if (!pwr_dn_n) begin
      st_d  = S_OFF;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        S_OFF: begin
          st_d  = S_LOCK;
          cnt_d = '0;
        end
        S_LOCK: if (cnt_q == LOCK_LAST) begin
          st_d  = S_CAL_LO;
          cnt_d = '0;
        end
        S_CAL_LO: if (cnt_q == SEG_LAST) begin
          st_d  = S_CAL_HI;
          cnt_d = '0;
        end
        S_CAL_HI: if (cnt_q == SEG_LAST) begin
          st_d  = S_CAL_BOTH;
          cnt_d = '0;
        end
        S_CAL_BOTH: if (cnt_q == SEG_LAST) begin
          st_d  = S_RUN;
          cnt_d = '0;
        end
        S_RUN: cnt_d = '0;
        default: begin
          st_d  = S_OFF;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;

  AST_DOWN_GOES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |=> st_q == S_OFF); // R1
  AST_LINKUP_ONLY_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LOCK && $past(st_q) != S_LOCK) |-> $past(st_q) == S_OFF); // R9
  AST_SEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CAL_LO || st_q == S_CAL_HI || st_q == S_CAL_BOTH) |-> cnt_q <= SEG_LAST); // R3
  AST_LOCK_TO_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CAL_LO && $past(st_q) != S_CAL_LO) |-> $past(st_q) == S_LOCK); // R2
endmodule

// File: rtl/lbu_clk_div.sv
module lbu_clk_div #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              lvl
);
  localparam int HW = 1 << RATE_W;

  logic [HW-1:0] half;
  logic [HW-1:0] hc_q;
  logic          lvl_q;
  logic          wrap;

  assign half = HW'(1) << rate_sel;
  assign wrap = (hc_q >= half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q  <= '0;
      lvl_q <= 1'b1;
    end else if (!run) begin
      hc_q  <= '0;
      lvl_q <= 1'b1;
    end else if (wrap) begin
      hc_q  <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      hc_q  <= hc_q + 1'b1;
    end
  end

  assign lvl = lvl_q;

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(rate_sel)) |-> hc_q < half); // R6
  AST_TOGGLE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && lvl_q != $past(lvl_q)) |-> $past(wrap)); // R6
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> lvl_q); // R6
endmodule

// File: rtl/lbu_line_mux.sv
module lbu_line_mux
  import link_bringup_pkg::*;
(
  input  seq_state_t state,
  input  logic       run_lvl,
  input  logic       tx_valid,
  input  logic       tx_bit,
  output logic       tx_ready,
  output logic       clk_oe,
  output logic       clk_lvl,
  output logic       dat_oe,
  output logic       dat_lvl,
  output phase_t     phase
);
  always_comb begin
    clk_oe   = 1'b0;
    clk_lvl  = 1'b0;
    dat_oe   = 1'b0;
    dat_lvl  = 1'b0;
    tx_ready = 1'b0;
    phase    = PH_LINKUP;
    unique case (state)
      S_OFF:      phase = PH_OFF;
      S_LOCK:     ;
      S_CAL_LO:   clk_oe = 1'b1;
      S_CAL_HI: begin
        clk_oe  = 1'b1;
        clk_lvl = 1'b1;
      end
      S_CAL_BOTH: begin
        clk_oe = 1'b1;
        dat_oe = 1'b1;
      end
      S_RUN: begin
        clk_oe   = 1'b1;
        clk_lvl  = run_lvl;
        dat_oe   = 1'b1;
        tx_ready = 1'b1;
        dat_lvl  = tx_valid & tx_bit;
        phase    = tx_valid ? PH_ACTIVE : PH_IDLE;
      end
      default:    phase = PH_OFF;
    endcase
  end

  always_comb begin
    assert (!dat_oe || clk_oe); // R5: data line never driven without the clock line
    assert (!(phase == PH_OFF) || !(clk_oe || dat_oe)); // R1
  end
endmodule

// File: rtl/link_bringup.sv
module link_bringup
  import link_bringup_pkg::*;
#(
  parameter int LOCK_CYC = 4096,
  parameter int SEG_CYC  = 11,
  parameter int RATE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              tx_valid,
  input  logic              tx_bit,
  output logic              tx_ready,
  output logic              clk_oe,
  output logic              clk_lvl,
  output logic              dat_oe,
  output logic              dat_lvl,
  output logic [1:0]        phase
);
  seq_state_t state;
  phase_t     phase_e;
  logic       run_lvl;

  lbu_step_fsm #(.LOCK_CYC(LOCK_CYC), .SEG_CYC(SEG_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn_n (pwr_dn_n),
    .state    (state)
  );

  lbu_clk_div #(.RATE_W(RATE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state == S_RUN),
    .rate_sel (rate_sel),
    .lvl      (run_lvl)
  );

  lbu_line_mux u_mux (
    .state    (state),
    .run_lvl  (run_lvl),
    .tx_valid (tx_valid),
    .tx_bit   (tx_bit),
    .tx_ready (tx_ready),
    .clk_oe   (clk_oe),
    .clk_lvl  (clk_lvl),
    .dat_oe   (dat_oe),
    .dat_lvl  (dat_lvl),
    .phase    (phase_e)
  );

  assign phase = phase_e;

  AST_READY_NEEDS_DRIVERS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (clk_oe && dat_oe)); // R8
  AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |-> (dat_oe && !dat_lvl)); // R7
endmodule

// File: tb/link_bringup_bench.sv
module link_bringup_bench;
  localparam int LOCK = 4096;
  localparam int SEG  = 11;
  localparam int RUN0 = LOCK + 3 * SEG;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_dn_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       tx_valid = 1'b0;
  logic       tx_bit = 1'b0;
  logic       tx_ready, clk_oe, clk_lvl, dat_oe, dat_lvl;
  logic [1:0] phase;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  link_bringup u_link_bringup (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .rate_sel(rate_sel),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .clk_oe(clk_oe), .clk_lvl(clk_lvl), .dat_oe(dat_oe), .dat_lvl(dat_lvl),
    .phase(phase)
  );

  // packed {phase[1:0], clk_oe, clk_lvl, dat_oe, dat_lvl, tx_ready}
  function automatic logic [6:0] exp_off();
    return 7'b00_0000_0;
  endfunction

  function automatic logic [6:0] exp_at(int n, int sel, bit v, bit b);
    int h;
    if (n < LOCK)           return 7'b01_0000_0;
    if (n < LOCK + SEG)     return 7'b01_1000_0;
    if (n < LOCK + 2 * SEG) return 7'b01_1100_0;
    if (n < RUN0)           return 7'b01_1010_0;
    h = 1 << sel;
    return {(v ? 2'd3 : 2'd2), 1'b1, (((n - RUN0) / h) % 2 == 0), 1'b1, v & b, 1'b1};
  endfunction

  function automatic string req_at(int n, bit v);
    if (n < LOCK)           return "R2";
    if (n < LOCK + SEG)     return "R3";
    if (n < LOCK + 2 * SEG) return "R4";
    if (n < RUN0)           return "R5";
    return v ? "R8/R6" : "R7/R6";
  endfunction

  task automatic check(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {phase, clk_oe, clk_lvl, dat_oe, dat_lvl, tx_ready};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at t=%0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // Release, follow the sequence to cycle abort_at, then power down.
  task automatic run_once(int sel, int abort_at, string tag);
    @(negedge clk);
    rate_sel = 2'(sel);
    pwr_dn_n = 1'b1;
    for (int n = 0; n <= abort_at; n++) begin
      @(posedge clk);
      #3;
      tx_valid = 1'($urandom);
      tx_bit   = 1'($urandom);
      #3;
      check((n == 0) ? tag : req_at(n, tx_valid), exp_at(n, sel, tx_valid, tx_bit));
    end
    pwr_dn_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #3;
      tx_valid = 1'b1;
      tx_bit   = 1'b1;
      #3;
      check("R1", exp_off());
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1'b1;
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    pwr_dn_n = 1'b1;
    tx_valid = 1'b1;
    tx_bit   = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset", exp_off());
    pwr_dn_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    check("R1 held down", exp_off());

    // directed: each rate with a stretch of running clock
    for (int s = 0; s < 4; s++) run_once(s, RUN0 + 70, "R9 restart");
    // directed aborts in the lock wait and in each preamble segment (R9)
    run_once(0, 100, "R9");
    run_once(1, LOCK + 4, "R9");
    run_once(2, LOCK + SEG + 6, "R9");
    run_once(3, LOCK + 2 * SEG + 10, "R9");
    run_once(1, 0, "R9");
    // random abort points and rates
    for (int r = 0; r < 5; r++) begin
      int sel;
      int ab;
      sel = int'($urandom % 4);
      ab  = int'($urandom % (RUN0 + 60));
      run_once(sel, ab, "R9");
    end
    // full run after the random mix: lock wait still exact
    run_once(3, RUN0 + 40, "R9 final");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule